// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block is the host-side engine that erases one block of a 16-bit-wide NAND flash over its asynchronous command, address and data bus. A single-cycle start request carries a block number. The sequencer then writes a guarded two-command erase: the setup opcode, the row address split over two address bytes, and the confirm opcode. The device begins erasing when the write strobe that carries the confirm opcode rises.

After the confirm, the sequencer waits for the device to finish. A mode bit, latched at start, picks how it waits. It can watch the ready/busy pin and then read status once. Or it can send the read-status opcode a single time and keep pulsing the read strobe until the ready bit shows. The fail bit of the final status byte sets the pass/fail result. A programmable limit bounds the wait. If the limit is reached, the sequencer writes the reset opcode and finishes with both the timeout and the fail flag set. All strobe widths are parameter cycle counts of the system clock.

Top module: `nand_erase_seq`

## Requirements
- R1: Out of reset, and whenever idle, chip enable, write strobe and read strobe are high (1); command latch, address latch, bus drive, busy and done are low (0); io_o is zero.
- R2: A start request while idle produces four bus writes back to back, beginning the cycle after start is sampled: opcode 60h with command latch high, two address writes with address latch high, then opcode D0h with command latch high. Each write lasts T_LO+T_HI cycles, with the write strobe low for the first T_LO cycles and data held for the whole write.
- R3: Address byte 0 is {blk[1:0], 6'b000000} and address byte 1 is blk[9:2]. The page bits are always driven as zero. io_o[15:8] is zero on every write.
- R4: In pin mode (poll_mode_i=0 at start), the bus idles with chip enable low for T_WB cycles after the confirm. The sequencer then samples rb_n_i every cycle. The cycle after rb_n_i is seen high, it writes opcode 70h and starts status reads.
- R5: In poll mode (poll_mode_i=1 at start), opcode 70h follows the confirm directly and is written only once. Status reads then repeat until status bit 6 (ready) is read as 1.
- R6: A status read holds the read strobe low for T_LO cycles and high for T_HI cycles, with bus drive off and the write strobe high. io_i is captured at the last low cycle.
- R7: On completion, done_o is high for exactly one cycle and busy_o is high during that cycle. busy_o falls on the next cycle. fail_o equals status bit 0 of the final read. fail_o and tmo_o hold until the next start.
- R8: Wait cycles are counted from the first cycle after the confirm. If the count has reached tmo_limit_i at a decision point (a pin-mode wait cycle with rb_n_i low, or the end of a status read with bit 6 clear), the sequencer writes opcode FFh and finishes with tmo_o=1 and fail_o=1. A ready indication takes priority over the limit.
- R9: A start request while busy_o is high has no effect on the running sequence or on its addresses.
- R10: After the confirm and until done, the only opcodes written are 70h and FFh.
- R11: Command latch and address latch are never high together. The read strobe is never low while the bus is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Erase request, sampled while idle |
| blk_addr_i | input | BLK_BITS | Block number to erase |
| poll_mode_i | input | 1 | 1: poll status register, 0: watch ready/busy pin |
| tmo_limit_i | input | TMO_W | Maximum wait cycles before abort |
| rb_n_i | input | 1 | Device ready/busy, high when ready |
| io_i | input | IO_W | Data bus read value |
| io_o | output | IO_W | Data bus write value |
| io_oe_o | output | 1 | Data bus drive enable |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| ce_n_o | output | 1 | Chip enable, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Erase failed or timed out |
| tmo_o | output | 1 | Wait limit reached |

## Verification
The bench checks the address split with blocks whose low two bits and high eight bits differ. A design that packed the block number without the six zero page bits would show the wrong byte on the first address write. Poll-mode runs return several not-ready reads before ready, to catch a design that rewrites 70h before every read or that stops after the first read. Timeouts are driven in both modes, and a zero limit is paired with an immediate ready, to catch a design that lets the limit override ready or that tests the limit one cycle off. A start pulse injected mid-erase catches a design that reloads the block number or restarts while busy.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR,
        ST_CONF,
        ST_WB,
        ST_RB,
        ST_SCMD,
        ST_SRD,
        ST_RST,
        ST_FIN
    } seq_state_e;

    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_RESET       = 8'hFF;

    localparam int STAT_READY_BIT = 6;
    localparam int STAT_FAIL_BIT  = 0;

endpackage

// File: rtl/nand_slot_timer.sv
module nand_slot_timer #(
    parameter int T_LO = 3,
    parameter int T_HI = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic strobe_lo_o,
    output logic sample_o,
    output logic last_o
);
    localparam int SLOT = T_LO + T_HI;
    localparam int CW   = (SLOT > 1) ? $clog2(SLOT) : 1;
    localparam logic [CW-1:0] LO_C   = CW'(T_LO);
    localparam logic [CW-1:0] SAMP_C = CW'(T_LO - 1);
    localparam logic [CW-1:0] LAST_C = CW'(SLOT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST_C) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign strobe_lo_o = run_i && (cnt_q < LO_C);
    assign sample_o    = run_i && (cnt_q == SAMP_C);
    assign last_o      = run_i && (cnt_q == LAST_C);

    // R2: a slot always starts from its first low cycle
    p_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

    // R6: the slot end is a single cycle, never two in a row
    p_last_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !last_o);

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q < limit_i) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q >= limit_i);

    // R8: the wait count restarts whenever the wait phase is left
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

    // R8: below the limit the count advances by one per wait cycle
    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !expired_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int IO_W      = 16,
    parameter int PAGE_BITS = 6,
    parameter int BLK_BITS  = 10,
    parameter int T_LO      = 3,
    parameter int T_HI      = 2,
    parameter int T_WB      = 20,
    parameter int TMO_W     = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [BLK_BITS-1:0] blk_addr_i,
    input  logic                poll_mode_i,
    input  logic [TMO_W-1:0]    tmo_limit_i,
    input  logic                rb_n_i,
    input  logic [IO_W-1:0]     io_i,
    output logic [IO_W-1:0]     io_o,
    output logic                io_oe_o,
    output logic                cle_o,
    output logic                ale_o,
    output logic                we_n_o,
    output logic                re_n_o,
    output logic                ce_n_o,
    output logic                busy_o,
    output logic                done_o,
    output logic                fail_o,
    output logic                tmo_o
);
    localparam int ROW_W     = PAGE_BITS + BLK_BITS;
    localparam int ADDR_CYC  = (ROW_W + 7) / 8;
    localparam int ROW_PAD_W = ADDR_CYC * 8;
    localparam int AIW       = (ADDR_CYC > 1) ? $clog2(ADDR_CYC) : 1;
    localparam int WBW       = (T_WB > 1) ? $clog2(T_WB) : 1;
    localparam logic [AIW-1:0] AIDX_LAST = AIW'(ADDR_CYC - 1);
    localparam logic [WBW-1:0] WB_LAST   = WBW'(T_WB - 1);

    typedef struct packed {
        seq_state_e          st;
        logic [AIW-1:0]      aidx;
        logic [WBW-1:0]      wb;
        logic [BLK_BITS-1:0] blk;
        logic                poll;
        logic                rdy;
        logic                sfail;
        logic                fail;
        logic                tmo;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic slot_run, wait_run;
    logic strobe_lo, sample, slot_last, tmo_hit;
    logic [ROW_PAD_W-1:0] row_w;
    logic [7:0] addr_byte, out_byte;
    logic unused_io;

    assign unused_io = ^{io_i[IO_W-1:STAT_READY_BIT+1], io_i[STAT_READY_BIT-1:STAT_FAIL_BIT+1]};

    assign slot_run = (r_q.st == ST_SETUP) || (r_q.st == ST_ADDR) || (r_q.st == ST_CONF) ||
                      (r_q.st == ST_SCMD)  || (r_q.st == ST_SRD)  || (r_q.st == ST_RST);
    assign wait_run = (r_q.st == ST_WB) || (r_q.st == ST_RB) ||
                      (r_q.st == ST_SCMD) || (r_q.st == ST_SRD);

    nand_slot_timer #(
        .T_LO (T_LO),
        .T_HI (T_HI)
    ) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (slot_run),
        .strobe_lo_o (strobe_lo),
        .sample_o    (sample),
        .last_o      (slot_last)
    );

    nand_busy_timer #(
        .W (TMO_W)
    ) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wait_run),
        .limit_i   (tmo_limit_i),
        .expired_o (tmo_hit)
    );

    assign row_w     = ROW_PAD_W'({r_q.blk, {PAGE_BITS{1'b0}}});
    assign addr_byte = row_w[8*int'(r_q.aidx) +: 8];

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st    = ST_SETUP;
                    r_d.blk   = blk_addr_i;
                    r_d.poll  = poll_mode_i;
                    r_d.aidx  = '0;
                    r_d.wb    = '0;
                    r_d.rdy   = 1'b0;
                    r_d.sfail = 1'b0;
                    r_d.fail  = 1'b0;
                    r_d.tmo   = 1'b0;
                end
            end
            ST_SETUP: begin
                if (slot_last) r_d.st = ST_ADDR;
            end
            ST_ADDR: begin
                if (slot_last) begin
                    if (r_q.aidx == AIDX_LAST) begin
                        r_d.st = ST_CONF;
                    end else begin
                        r_d.aidx = r_q.aidx + 1'b1;
                    end
                end
            end
            ST_CONF: begin
                if (slot_last) begin
                    r_d.wb = '0;
                    r_d.st = r_q.poll ? ST_SCMD : ST_WB;
                end
            end
            ST_WB: begin
                if (r_q.wb == WB_LAST) begin
                    r_d.st = ST_RB;
                end else begin
                    r_d.wb = r_q.wb + 1'b1;
                end
            end
            ST_RB: begin
                if (rb_n_i) begin
                    r_d.st = ST_SCMD;
                end else if (tmo_hit) begin
                    r_d.st = ST_RST;
                end
            end
            ST_SCMD: begin
                if (slot_last) r_d.st = ST_SRD;
            end
            ST_SRD: begin
                if (sample) begin
                    r_d.rdy   = io_i[STAT_READY_BIT];
                    r_d.sfail = io_i[STAT_FAIL_BIT];
                end
                if (slot_last) begin
                    if (r_q.rdy) begin
                        r_d.st   = ST_FIN;
                        r_d.fail = r_q.sfail;
                    end else if (tmo_hit) begin
                        r_d.st = ST_RST;
                    end
                end
            end
            ST_RST: begin
                if (slot_last) begin
                    r_d.st   = ST_FIN;
                    r_d.fail = 1'b1;
                    r_d.tmo  = 1'b1;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            ST_SETUP: out_byte = OP_ERASE_SETUP;
            ST_ADDR:  out_byte = addr_byte;
            ST_CONF:  out_byte = OP_ERASE_GO;
            ST_SCMD:  out_byte = OP_STATUS;
            ST_RST:   out_byte = OP_RESET;
            default:  out_byte = 8'h00;
        endcase
    end

    assign io_o    = IO_W'(out_byte);
    assign io_oe_o = slot_run && (r_q.st != ST_SRD);
    assign cle_o   = (r_q.st == ST_SETUP) || (r_q.st == ST_CONF) ||
                     (r_q.st == ST_SCMD)  || (r_q.st == ST_RST);
    assign ale_o   = (r_q.st == ST_ADDR);
    assign we_n_o  = !(strobe_lo && (r_q.st != ST_SRD));
    assign re_n_o  = !(strobe_lo && (r_q.st == ST_SRD));
    assign ce_n_o  = (r_q.st == ST_IDLE) || (r_q.st == ST_FIN);
    assign busy_o  = (r_q.st != ST_IDLE);
    assign done_o  = (r_q.st == ST_FIN);
    assign fail_o  = r_q.fail;
    assign tmo_o   = r_q.tmo;

    // R11: latch enables are mutually exclusive
    p_latch_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    // R11: no read strobe while the bus is driven
    p_no_contend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_oe_o && !re_n_o));

    // R7: done is a single-cycle pulse followed by idle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8: a timeout always reports failure
    p_tmo_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |-> fail_o);

    // R9: a start seen while busy leaves the latched block alone
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(r_q.blk));

    // R10: after the confirm only status and reset opcodes are written
    p_wait_cmds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_run && cle_o && !we_n_o) |-> (io_o[7:0] == OP_STATUS));

    // R2: the confirm write is entered only from the address phase
    p_conf_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_CONF) && ($past(r_q.st) != ST_CONF)) |-> ($past(r_q.st) == ST_ADDR));

endmodule

// File: tb/nand_erase_seq_tb.sv
module nand_erase_seq_tb_top;

    localparam int T_LO = 3;
    localparam int T_HI = 2;
    localparam int T_WB = 20;
    localparam int SLOT = T_LO + T_HI;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  blk_addr_i = '0;
    logic        poll_mode_i = 1'b0;
    logic [15:0] tmo_limit_i = 16'd1000;
    logic        rb_n_i = 1'b1;
    logic [15:0] io_i = '0;
    logic [15:0] io_o;
    logic        io_oe_o, cle_o, ale_o, we_n_o, re_n_o, ce_n_o;
    logic        busy_o, done_o, fail_o, tmo_o;

    int checks = 0;
    int errors = 0;
    int wn = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nand_erase_seq #(
        .IO_W(16), .PAGE_BITS(6), .BLK_BITS(10),
        .T_LO(T_LO), .T_HI(T_HI), .T_WB(T_WB), .TMO_W(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_addr_i(blk_addr_i),
        .poll_mode_i(poll_mode_i), .tmo_limit_i(tmo_limit_i), .rb_n_i(rb_n_i),
        .io_i(io_i), .io_o(io_o), .io_oe_o(io_oe_o), .cle_o(cle_o), .ale_o(ale_o),
        .we_n_o(we_n_o), .re_n_o(re_n_o), .ce_n_o(ce_n_o), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .tmo_o(tmo_o)
    );

    // order: ce_n cle ale we_n re_n oe io[15:0] busy done fail tmo
    function automatic logic [25:0] pk(logic ce_n, logic cle, logic ale, logic we_n,
                                       logic re_n, logic oe, logic [15:0] io,
                                       logic bsy, logic dn, logic fl, logic to);
        return {ce_n, cle, ale, we_n, re_n, oe, io, bsy, dn, fl, to};
    endfunction

    task automatic chk(string req, logic [25:0] exp_v);
        logic [25:0] act;
        act = pk(ce_n_o, cle_o, ale_o, we_n_o, re_n_o, io_oe_o, io_o,
                 busy_o, done_o, fail_o, tmo_o);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp_v);
        end
    endtask

    // one bus write, checked cycle by cycle; counts wait cycles if asked
    task automatic wr_slot(string req, logic cle, logic ale, logic [7:0] val, bit in_wait);
        for (int c = 0; c < SLOT; c++) begin
            chk(req, pk(1'b0, cle, ale, (c < T_LO) ? 1'b0 : 1'b1, 1'b1, 1'b1,
                        {8'h00, val}, 1'b1, 1'b0, 1'b0, 1'b0));
            if (in_wait) wn++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(logic [9:0] blk, bit poll, int limit, int rb_rise,
                          int ready_read, bit fbit, int ign_at);
        bit timed_out;
        bit fin_fail;
        int k;
        logic [15:0] row;
        @(negedge clk);
        blk_addr_i = blk; poll_mode_i = poll; tmo_limit_i = 16'(limit);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        rb_n_i = 1'b0;
        blk_addr_i = ~blk;
        poll_mode_i = ~poll;
        wn = 0;
        timed_out = 1'b0;
        fin_fail = 1'b0;
        row = {blk, 6'b000000};
        wr_slot("R2 setup", 1'b1, 1'b0, 8'h60, 1'b0);
        wr_slot("R3 addr0", 1'b0, 1'b1, row[7:0], 1'b0);
        wr_slot("R3 addr1", 1'b0, 1'b1, row[15:8], 1'b0);
        wr_slot("R2 confirm", 1'b1, 1'b0, 8'hD0, 1'b0);
        if (!poll) begin
            while (1) begin
                rb_n_i = (wn >= rb_rise);
                start_i = (wn == ign_at);
                blk_addr_i = 10'h155;
                chk("R4 wait", pk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0,
                                  1'b1, 1'b0, 1'b0, 1'b0));
                if (wn >= T_WB) begin
                    if (rb_n_i) begin
                        wn++; @(negedge clk); break;
                    end else if (wn >= limit) begin
                        timed_out = 1'b1; wn++; @(negedge clk); break;
                    end
                end
                wn++;
                @(negedge clk);
            end
            start_i = 1'b0;
        end
        if (!timed_out) begin
            wr_slot(poll ? "R5 status cmd" : "R4 status cmd", 1'b1, 1'b0, 8'h70, 1'b1);
            k = 0;
            while (1) begin
                bit rdy;
                bit leave;
                rdy = (k >= ready_read);
                leave = 1'b0;
                for (int c = 0; c < SLOT; c++) begin
                    io_i = 16'hA520 | (rdy ? 16'h0040 : 16'h0000) | {15'h0, fbit};
                    chk("R6 read", pk(1'b0, 1'b0, 1'b0, 1'b1, (c < T_LO) ? 1'b0 : 1'b1,
                                      1'b0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0));
                    if (c == SLOT - 1) begin
                        if (rdy) begin
                            leave = 1'b1; fin_fail = fbit;
                        end else if (wn >= limit) begin
                            leave = 1'b1; timed_out = 1'b1;
                        end
                    end
                    wn++;
                    @(negedge clk);
                end
                if (leave) break;
                k++;
            end
        end
        if (timed_out) begin
            wr_slot("R8 reset cmd", 1'b1, 1'b0, 8'hFF, 1'b1);
            fin_fail = 1'b1;
        end
        chk("R7 done", pk(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0,
                          1'b1, 1'b1, fin_fail, timed_out));
        @(negedge clk);
        chk("R7 after done", pk(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0,
                                1'b0, 1'b0, fin_fail, timed_out));
        rb_n_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", pk(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0,
                           1'b0, 1'b0, 1'b0, 1'b0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", pk(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0,
                          1'b0, 1'b0, 1'b0, 1'b0));
        // R4 pin mode pass, with R9 start injected during the wait
        run_op(10'h2A5, 1'b0, 1000, 35, 0, 1'b0, 5);
        // R5 poll mode, three not-ready reads then a failed erase
        run_op(10'h3FF, 1'b1, 1000, 0, 3, 1'b1, -1);
        // R8 timeout in pin mode
        run_op(10'h0C3, 1'b0, 30, 100000, 0, 1'b0, -1);
        // R8 timeout in poll mode
        run_op(10'h101, 1'b1, 25, 0, 100000, 1'b0, -1);
        // R8 zero limit, ready wins
        run_op(10'h000, 1'b1, 0, 0, 0, 1'b0, -1);
        // R3 second address after the ignored start, pin mode
        run_op(10'h17E, 1'b0, 1000, 21, 0, 1'b1, -1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule